// File: doc/BRIEF.md
# Supervisor Event Router

This block collects the event and status signals of a power-supply supervisor and decides, for each source, whether it should raise an interrupt, request a system reset, or be dropped. The decision uses the source's enable bit and the operating mode current at the time of the event. The sources are:

- level signals: temperature warning, ground shift, battery sense pin, wake pin and regulator short;
- two multi-bit bus failure-status vectors;
- single-cycle strobes: watchdog overflow, two bus wake-ups and a serial-port clock-count failure.

Level inputs pass through a synchronizer. Each edge or change is then found by comparing the synchronized value with a registered copy from the previous clock. Strobes and the mode code pass through a pipeline of the same depth, so that they stay aligned with the levels. A source that is routed to an interrupt sets a sticky flag, which software clears by writing a one to it. The interrupt line is the OR of all flags. A source routed to a reset produces a one-cycle reset request.

A small control state machine sequences the block. The states are:

- ST_PRIME: entered at reset. It lasts SYNC_STAGES+1 cycles, so the synchronizer can fill without spurious edges.
- ST_WATCH: normal operation.
- ST_FIRE: the reset-request cycle.

The transitions are:

- prime-done: ST_PRIME to ST_WATCH.
- reset-request: ST_WATCH to ST_FIRE.
- pulse-end: ST_FIRE to ST_WATCH, taken unconditionally.

Top module: `irq_rst_router`

## Requirements
- R1: While reset is held, flags_o, irq_o and rst_req_o are 0. Input changes seen in the first SYNC_STAGES+1 cycles after reset release produce no flag and no reset request.
- R2: Mode codes are: start-up 0, restart 1, standby 2, normal 3, flash 4, sleep 5. A watchdog overflow strobe in standby sets flag bit 0 when enable bit 0 is 1. A watchdog overflow strobe in standby with enable bit 0 at 0 requests a reset. In every other mode it requests a reset regardless of the enable.
- R3: With enable bit 1 at 1, a temperature-warning change in either direction sets flag bit 1. With enable bit 2 at 1, a ground-shift change in either direction sets flag bit 2. With the enable at 0, nothing happens.
- R4: With enable bit 3 at 1, a falling edge on the sense input sets flag bit 3. A rising edge has no effect.
- R5: With enable bit 4 at 1, a rising edge on the regulator-short input sets flag bit 4. Its falling edge has no effect.
- R6: With its enable at 1, any bit change in the first bus failure vector sets flag bit 5. With its enable at 1, any bit change in the second bus failure vector sets flag bit 6.
- R7: A falling edge on the wake input sets flag bit 7 when enable bit 7 is 1 and the mode is standby, normal or flash. It requests a reset when enable bit 7 is 0 and the mode is standby. Otherwise it does nothing, and a rising edge never acts.
- R8: A wake-up strobe from the first bus sets flag bit 8 when its enable is 1 and requests a reset otherwise. A wake-up strobe from the second bus does the same with flag bit 9 and enable bit 9.
- R9: A clock-count failure strobe requests a reset in start-up and restart modes, whatever the enable. In other modes it sets flag bit 10 when enable bit 10 is 1 and does nothing otherwise.
- R10: Flags stay set until cleared by writing 1 to the matching clr_i bit. A set and a clear on the same edge leave the flag set. irq_o is 1 exactly when any flag is set.
- R11: rst_req_o is high for exactly one cycle per accepted request. Requests decided during that cycle are dropped.
- R12: When any source requests a reset in a decision cycle, no flag is set in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode code |
| en_i | input | 11 | Per-source enable, indexed as the flag bits |
| clr_i | input | 11 | Write-one-to-clear strobes for the flags |
| wd_ovf_i | input | 1 | Watchdog overflow strobe |
| temp_warn_i | input | 1 | Temperature warning level |
| gnd_shift_i | input | 1 | Ground-shift comparator level |
| sense_i | input | 1 | Battery sense pin level |
| wake_i | input | 1 | Wake pin level |
| supply_short_i | input | 1 | Regulator short-circuit flag |
| can_fail_i | input | FAIL_W | First bus failure-status vector |
| lin_fail_i | input | FAIL_W | Second bus failure-status vector |
| can_wake_i | input | 1 | First bus wake-up strobe |
| lin_wake_i | input | 1 | Second bus wake-up strobe |
| spi_cnt_fail_i | input | 1 | Serial clock-count failure strobe |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |
| flags_o | output | 11 | Sticky interrupt flags |

## Verification
Flag and reset results arrive on the SYNC_STAGES+1-th rising edge after a stimulus: with the default depth of 2 this is the third edge. The three edges are spent in two synchronizer stages and one flag or state register. A clr_i write takes effect on the first edge. The reset request drops again on the edge after it rises. The bench drives every input just after a falling edge. It counts falling edges and samples at the falling edge that follows the due rising edge, so each check sees a settled value. The strobes are held for exactly one cycle.

// File: rtl/irr_pkg.sv
package irr_pkg;

    localparam int NSRC = 11;

    localparam int SRC_WDOG   = 0;
    localparam int SRC_TEMP   = 1;
    localparam int SRC_GSHIFT = 2;
    localparam int SRC_BATT   = 3;
    localparam int SRC_SUPPLY = 4;
    localparam int SRC_CANF   = 5;
    localparam int SRC_LINF   = 6;
    localparam int SRC_WAKE   = 7;
    localparam int SRC_CANW   = 8;
    localparam int SRC_LINW   = 9;
    localparam int SRC_SPIF   = 10;

    localparam logic [2:0] MD_STARTUP = 3'd0;
    localparam logic [2:0] MD_RESTART = 3'd1;
    localparam logic [2:0] MD_STANDBY = 3'd2;
    localparam logic [2:0] MD_NORMAL  = 3'd3;
    localparam logic [2:0] MD_FLASH   = 3'd4;
    localparam logic [2:0] MD_SLEEP   = 3'd5;

    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_WATCH = 2'd1,
        ST_FIRE  = 2'd2
    } state_e;

endpackage

// File: rtl/irr_sync.sv
module irr_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (STAGES < 1) begin : g_pass
            logic unused_clk;
            assign unused_clk = clk_i ^ rst_ni;
            assign q_o = d_i;
        end else begin : g_pipe
            logic [W-1:0] stg [STAGES];

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d_i;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end

            assign q_o = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/irr_edge.sv
module irr_edge #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] chg_o
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= lvl_i;
    end

    assign chg_o = lvl_i ^ prev_q;

endmodule

// File: rtl/irr_decide.sv
module irr_decide
    import irr_pkg::*;
(
    input  logic [NSRC-1:0] en_i,
    input  logic [2:0]      mode_i,
    input  logic            wdog_i,
    input  logic            canw_i,
    input  logic            linw_i,
    input  logic            spif_i,
    input  logic            temp_chg_i,
    input  logic            gnd_chg_i,
    input  logic            sense_fall_i,
    input  logic            supply_rise_i,
    input  logic            canf_chg_i,
    input  logic            linf_chg_i,
    input  logic            wake_fall_i,
    output logic [NSRC-1:0] set_o,
    output logic            rst_o
);

    logic in_standby;
    logic in_wakeable;
    logic in_boot;

    always_comb begin
        in_standby  = 1'b0;
        in_wakeable = 1'b0;
        in_boot     = 1'b0;
        case (mode_i)
            MD_STARTUP, MD_RESTART: in_boot = 1'b1;
            MD_STANDBY: begin
                in_standby  = 1'b1;
                in_wakeable = 1'b1;
            end
            MD_NORMAL, MD_FLASH: in_wakeable = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        set_o = '0;
        rst_o = 1'b0;

        if (wdog_i) begin
            if (in_standby && en_i[SRC_WDOG]) set_o[SRC_WDOG] = 1'b1;
            else                              rst_o = 1'b1;
        end

        set_o[SRC_TEMP]   = temp_chg_i    & en_i[SRC_TEMP];
        set_o[SRC_GSHIFT] = gnd_chg_i     & en_i[SRC_GSHIFT];
        set_o[SRC_BATT]   = sense_fall_i  & en_i[SRC_BATT];
        set_o[SRC_SUPPLY] = supply_rise_i & en_i[SRC_SUPPLY];
        set_o[SRC_CANF]   = canf_chg_i    & en_i[SRC_CANF];
        set_o[SRC_LINF]   = linf_chg_i    & en_i[SRC_LINF];

        if (wake_fall_i) begin
            if (en_i[SRC_WAKE] && in_wakeable)     set_o[SRC_WAKE] = 1'b1;
            else if (!en_i[SRC_WAKE] && in_standby) rst_o = 1'b1;
        end

        if (canw_i) begin
            if (en_i[SRC_CANW]) set_o[SRC_CANW] = 1'b1;
            else                rst_o = 1'b1;
        end

        if (linw_i) begin
            if (en_i[SRC_LINW]) set_o[SRC_LINW] = 1'b1;
            else                rst_o = 1'b1;
        end

        if (spif_i) begin
            if (in_boot)             rst_o = 1'b1;
            else if (en_i[SRC_SPIF]) set_o[SRC_SPIF] = 1'b1;
        end
    end

endmodule

// File: rtl/irr_ctrl.sv
module irr_ctrl
    import irr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] set_i,
    input  logic            rst_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flags_o,
    output logic            irq_o,
    output logic            rst_req_o,
    output logic            active_o
);

    localparam int CW = $clog2(SYNC_STAGES + 2) + 1;

    state_e        state_q;
    state_e        state_d;
    logic [CW-1:0] cnt_q;
    logic          primed;
    logic          take_set;
    logic          fire;

    assign primed = (cnt_q == CW'(SYNC_STAGES));

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_PRIME;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PRIME) cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (primed) state_d = ST_WATCH;
            ST_WATCH: if (rst_i)  state_d = ST_FIRE;
            ST_FIRE:              state_d = ST_WATCH;
            default:              state_d = ST_PRIME;
        endcase
    end

    // outputs of the state
    always_comb begin
        active_o = 1'b0;
        take_set = 1'b0;
        fire     = 1'b0;
        unique case (state_q)
            ST_PRIME: ;
            ST_WATCH: begin
                active_o = 1'b1;
                take_set = !rst_i;
            end
            ST_FIRE: begin
                active_o = 1'b1;
                take_set = !rst_i;
                fire     = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flags_o <= '0;
        else         flags_o <= (flags_o & ~clr_i) | (take_set ? set_i : '0);
    end

    assign irq_o     = |flags_o;
    assign rst_req_o = fire;

endmodule

// File: rtl/irq_rst_router.sv
module irq_rst_router
    import irr_pkg::*;
#(
    parameter int FAIL_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        mode_i,
    input  logic [NSRC-1:0]   en_i,
    input  logic [NSRC-1:0]   clr_i,
    input  logic              wd_ovf_i,
    input  logic              temp_warn_i,
    input  logic              gnd_shift_i,
    input  logic              sense_i,
    input  logic              wake_i,
    input  logic              supply_short_i,
    input  logic [FAIL_W-1:0] can_fail_i,
    input  logic [FAIL_W-1:0] lin_fail_i,
    input  logic              can_wake_i,
    input  logic              lin_wake_i,
    input  logic              spi_cnt_fail_i,
    output logic              irq_o,
    output logic              rst_req_o,
    output logic [NSRC-1:0]   flags_o
);

    localparam int LVL_W  = 5 + 2 * FAIL_W;
    localparam int STB_W  = 4;
    localparam int BUS_W  = LVL_W + STB_W + 3;
    localparam int L_TEMP = 0;
    localparam int L_GND  = 1;
    localparam int L_SNS  = 2;
    localparam int L_SUP  = 3;
    localparam int L_WAKE = 4;
    localparam int L_CANF = 5;
    localparam int L_LINF = 5 + FAIL_W;

    logic [BUS_W-1:0] raw_bus;
    logic [BUS_W-1:0] sync_bus;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] chg;
    logic [STB_W-1:0] stb_q;
    logic [2:0]       mode_q;
    logic [NSRC-1:0]  set_raw;
    logic             rst_raw;
    logic             active;

    assign raw_bus = {mode_i, spi_cnt_fail_i, lin_wake_i, can_wake_i, wd_ovf_i,
                      lin_fail_i, can_fail_i, wake_i, supply_short_i, sense_i,
                      gnd_shift_i, temp_warn_i};

    irr_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_bus),
        .q_o    (sync_bus)
    );

    assign lvl_q  = sync_bus[LVL_W-1:0];
    assign stb_q  = sync_bus[LVL_W +: STB_W];
    assign mode_q = sync_bus[LVL_W+STB_W +: 3];

    irr_edge #(.W(LVL_W)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (lvl_q),
        .chg_o  (chg)
    );

    irr_decide u_decide (
        .en_i          (en_i),
        .mode_i        (mode_q),
        .wdog_i        (stb_q[0]),
        .canw_i        (stb_q[1]),
        .linw_i        (stb_q[2]),
        .spif_i        (stb_q[3]),
        .temp_chg_i    (chg[L_TEMP]),
        .gnd_chg_i     (chg[L_GND]),
        .sense_fall_i  (chg[L_SNS] & ~lvl_q[L_SNS]),
        .supply_rise_i (chg[L_SUP] & lvl_q[L_SUP]),
        .canf_chg_i    (|chg[L_CANF +: FAIL_W]),
        .linf_chg_i    (|chg[L_LINF +: FAIL_W]),
        .wake_fall_i   (chg[L_WAKE] & ~lvl_q[L_WAKE]),
        .set_o         (set_raw),
        .rst_o         (rst_raw)
    );

    irr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (set_raw),
        .rst_i     (rst_raw),
        .clr_i     (clr_i),
        .flags_o   (flags_o),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o),
        .active_o  (active)
    );

endmodule

// File: rtl/irr_checker.sv
module irr_checker
    import irr_pkg::*;
(
    input logic            clk_i,
    input logic            rst_ni,
    input logic [NSRC-1:0] en_i,
    input logic [NSRC-1:0] clr_i,
    input logic [NSRC-1:0] flags_o,
    input logic            rst_req_o,
    input logic            active
);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> !rst_req_o); // R11

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(flags_o) & ~$past(clr_i) & ~flags_o) == '0)); // R10

    AST_RESET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_req_o) |-> ((flags_o & ~$past(flags_o)) == '0)); // R12

    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(en_i)) == '0)); // R3

    AST_PRIME_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active |-> (flags_o == '0 && !rst_req_o)); // R1

endmodule

bind irq_rst_router irr_checker u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .clr_i     (clr_i),
    .flags_o   (flags_o),
    .rst_req_o (rst_req_o),
    .active    (active)
);

// File: tb/tb_irq_rst_router.sv
module tb_irq_rst_router;
    import irr_pkg::*;

    localparam int CLK_P  = 10;
    localparam int FW     = 3;
    localparam int WD_CYC = 150000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [2:0]      mode;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] clr;
    logic            wd, temp, gnd, sense, wake, sup, canw, linw, spif;
    logic [FW-1:0]   canf, linf;
    logic            irq, rstq;
    logic [NSRC-1:0] flags;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    irq_rst_router #(.FAIL_W(FW), .SYNC_STAGES(2)) dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .en_i(en), .clr_i(clr),
        .wd_ovf_i(wd), .temp_warn_i(temp), .gnd_shift_i(gnd), .sense_i(sense),
        .wake_i(wake), .supply_short_i(sup), .can_fail_i(canf), .lin_fail_i(linf),
        .can_wake_i(canw), .lin_wake_i(linw), .spi_cnt_fail_i(spif),
        .irq_o(irq), .rst_req_o(rstq), .flags_o(flags)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(int a);
        case (a)
            0:       return "R2";
            1, 2:    return "R3";
            3:       return "R4";
            4:       return "R5";
            5, 6:    return "R6";
            7:       return "R7";
            8, 9:    return "R8";
            default: return "R9";
        endcase
    endfunction

    // expected {reset, flag mask} for one action
    function automatic logic [NSRC:0] expect_of(int a, bit e, int m, bit old);
        logic [NSRC-1:0] mk = '0;
        bit r   = 0;
        bit sb  = (m == 2);
        bit nfs = (m >= 2 && m <= 4);
        bit su  = (m <= 1);
        case (a)
            0:       if (sb && e) mk[0] = 1'b1; else r = 1;
            1, 2:    mk[a] = e;
            3:       mk[3] = e && old;
            4:       mk[4] = e && !old;
            5, 6:    mk[a] = e;
            7:       if (old) begin
                         if (e && nfs)      mk[7] = 1'b1;
                         else if (!e && sb) r = 1;
                     end
            8, 9:    if (e) mk[a] = 1'b1; else r = 1;
            default: if (su) r = 1; else if (e) mk[10] = 1'b1;
        endcase
        return {r, mk};
    endfunction

    function automatic bit old_of(int a);
        case (a)
            3:       return sense;
            4:       return sup;
            7:       return wake;
            default: return 1'b0;
        endcase
    endfunction

    // drive one action at the current falling edge, return when result is due
    task automatic apply(int a, int k);
        case (a)
            0:  wd   = 1'b1;
            1:  temp = ~temp;
            2:  gnd  = ~gnd;
            3:  sense = ~sense;
            4:  sup  = ~sup;
            5:  canf[k % FW] = ~canf[k % FW];
            6:  linf[k % FW] = ~linf[k % FW];
            7:  wake = ~wake;
            8:  canw = 1'b1;
            9:  linw = 1'b1;
            default: spif = 1'b1;
        endcase
        tick(1);
        wd = 1'b0; canw = 1'b0; linw = 1'b0; spif = 1'b0;
        tick(2);
    endtask

    task automatic clear_all();
        clr = '1;
        tick(1);
        clr = '0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; mode = 3'd3; en = '1; clr = '0;
        wd = 0; gnd = 0; sense = 0; wake = 0; sup = 0;
        canw = 0; linw = 0; spif = 0; canf = '0; linf = '0;
        temp = 1'b1;                         // high through reset and priming
        tick(3);
        chk("R1", "flags in reset", int'(flags), 0);
        chk("R1", "irq in reset", int'(irq), 0);
        chk("R1", "rst_req in reset", int'(rstq), 0);
        rst_n = 1'b1;
        tick(6);
        chk("R1", "flags after priming", int'(flags), 0);
        chk("R1", "rst_req after priming", int'(rstq), 0);
        en = '0; temp = 1'b0;
        tick(4);
        clear_all();
        tick(1);

        // R12: reset request and interrupt in the same decision cycle
        en = '1; en[SRC_CANW] = 1'b0; mode = 3'd3;
        canw = 1'b1; temp = ~temp;
        tick(1); canw = 1'b0; tick(2);
        chk("R12", "rst_req on collision", int'(rstq), 1);
        chk("R12", "flags on collision", int'(flags), 0);
        tick(1); clear_all(); tick(1);

        // R10: set and clear on the same edge, then partial clear
        en = '1;
        gnd = ~gnd; sup = 1'b1;
        tick(2); clr[SRC_GSHIFT] = 1'b1; tick(1); clr = '0;
        chk("R10", "set beats clear", int'(flags), (1 << SRC_GSHIFT) | (1 << SRC_SUPPLY));
        clr[SRC_SUPPLY] = 1'b1; tick(1); clr = '0;
        chk("R10", "partial clear", int'(flags), 1 << SRC_GSHIFT);
        chk("R10", "irq with one flag", int'(irq), 1);
        clear_all();
        chk("R10", "irq after clear", int'(irq), 0);
        sup = 1'b0; tick(4); clear_all(); tick(1);

        // R11: back-to-back reset requests
        en = '0;
        canw = 1'b1; tick(1); canw = 1'b0; linw = 1'b1; tick(1); linw = 1'b0; tick(1);
        chk("R11", "first pulse", int'(rstq), 1);
        tick(1);
        chk("R11", "second request dropped", int'(rstq), 0);
        tick(3); clear_all(); tick(1);

        // sweep: modes x enable x source x two directions
        for (int m = 0; m < 7; m++) begin
            for (int e = 0; e < 2; e++) begin
                for (int a = 0; a < NSRC; a++) begin
                    for (int k = 0; k < 2; k++) begin
                        logic [NSRC:0] ex;
                        mode = 3'(m);
                        en   = e[0] ? '1 : '0;
                        ex   = expect_of(a, e[0], m, old_of(a));
                        apply(a, m + k);
                        chk(tag_of(a), "flags", int'(flags), int'(ex[NSRC-1:0]));
                        chk("R10", "irq", int'(irq), int'(ex[NSRC-1:0] != '0));
                        chk(tag_of(a), "rst_req", int'(rstq), int'(ex[NSRC]));
                        tick(1);
                        chk("R11", "rst_req drops", int'(rstq), 0);
                        clear_all();
                        chk("R10", "cleared", int'(flags), 0);
                    end
                end
            end
        end

        done = 1;
        finish_run();
    end

endmodule